// File: doc/BRIEF.md
# ADD Opcode Field Decoder

This block turns the raw bytes of one captured ADD-family instruction into clean operand controls for a later execute stage. It is given the primary opcode byte, the addressing byte that follows it, a flag saying whether the operand-size override prefix (66h) came before the opcode, and up to four immediate bytes in little-endian order. From these it works out the operand width, which operand is the destination, whether each operand is a register or a memory operand, and whether an immediate is present. When there is an immediate, it also produces that immediate sign-extended to 32 bits.

The forms it recognises are the two-operand register forms (00h to 03h), the short accumulator-immediate forms (04h, 05h) and the group-immediate forms (80h, 81h, 83h). In the group-immediate forms the middle field of the addressing byte is an opcode extension. A non-zero value there raises a bad-extension flag. Any other opcode raises an unsupported flag and leaves every control at zero. Address arithmetic and the adder itself sit outside this block. A decode is requested with a one-cycle valid strobe, and the results appear registered on the next clock edge.

Top module: `addop_decode`

## Requirements
- R1: One clock edge after `in_valid` is high, `out_valid` is high and the decoded fields are shown; `out_valid` is low after any edge where `in_valid` was low. After reset every output is zero.
- R2: For opcodes 00h–03h, opcode bit 0 picks the width: 0 gives 8 bits (`width_code`=0), 1 gives 32 bits (`width_code`=2), or 16 bits (`width_code`=1) when `pfx_opsize` is high.
- R3: For opcodes 00h–03h, opcode bit 1 picks the direction: 0 makes the addressing byte's operand field (bits 2:0) the destination and its register field (bits 5:3) the source; 1 swaps them.
- R4: An addressing byte whose mode bits 7:6 are 11 names a register in bits 2:0. Any other mode makes that operand a memory operand (`dst_mem`=1, or `src_kind`=1), with bits 2:0 still reported as its number. A register-field operand is always a register (`src_kind`=0). No decode has two memory operands.
- R5: Opcode 80h is an 8-bit immediate add. The destination is the addressing-byte operand, `src_kind`=2, and the immediate is `imm_bytes[7:0]` sign-extended to 32 bits.
- R6: Opcode 81h takes an immediate of the full operand width. Without the prefix this is 32 bits, `imm_bytes[31:0]`. With the prefix it is `imm_bytes[15:0]`, sign-extended to 32 bits, with `width_code`=1.
- R7: Opcode 83h uses a 16- or 32-bit operand width, set by the prefix, with `imm_bytes[7:0]` sign-extended to 32 bits.
- R8: For 80h, 81h and 83h, a non-zero register field (addressing bits 5:3) sets `ext_bad`. For every other opcode `ext_bad` is 0.
- R9: Opcode 04h (8-bit) and opcode 05h (full width, with the immediate sized as in R6) add an immediate to register 0. They report `dst_mem`=0, `dst_num`=0 and `src_kind`=2, and their outputs do not depend on the addressing byte.
- R10: Any opcode outside {00h–05h, 80h, 81h, 83h} sets `unsupported`. All other decoded outputs are then zero.
- R11: The prefix has no effect on the 8-bit forms 00h, 02h, 04h and 80h: `width_code` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode request strobe |
| op_byte | input | 8 | Primary opcode byte |
| modrm_byte | input | 8 | Addressing byte (mode 7:6, register field 5:3, operand field 2:0) |
| pfx_opsize | input | 1 | Operand-size override prefix was present |
| imm_bytes | input | 32 | Immediate bytes, first byte in bits 7:0 |
| out_valid | output | 1 | Decoded fields valid |
| width_code | output | 2 | 0 = 8 bit, 1 = 16 bit, 2 = 32 bit |
| dst_mem | output | 1 | Destination is a memory operand |
| dst_num | output | 3 | Destination register / operand-field number |
| src_kind | output | 2 | 0 = register, 1 = memory, 2 = immediate |
| src_num | output | 3 | Source register / operand-field number (0 for immediate) |
| has_imm | output | 1 | Instruction carries an immediate |
| imm_value | output | 32 | Immediate sign-extended to 32 bits |
| ext_bad | output | 1 | Immediate group with non-zero opcode extension |
| unsupported | output | 1 | Opcode not in the recognised ADD set |

## Verification
On every cycle the assertions check the valid timing and these consistency rules: at most one opcode form is matched, no decode has two memory operands, an 8-bit immediate carries the right sign extension, and an unsupported or bad-extension decode never contradicts itself. Only the bench's scenarios can show that each opcode gives the right width, direction, operand numbers and immediate value, that the prefix leaves the 8-bit forms alone, and that the accumulator forms ignore the addressing byte.

// File: rtl/addop_pkg.sv
package addop_pkg;

  parameter int unsigned IMM_BITS = 32;
  parameter int unsigned OPB_BITS = 8;
  parameter int unsigned RNUM_BITS = 3;

  typedef enum logic [1:0] {
    OPW_8  = 2'd0,
    OPW_16 = 2'd1,
    OPW_32 = 2'd2
  } opw_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_MEM = 2'd1,
    SRC_IMM = 2'd2
  } srck_e;

  typedef struct packed {
    logic is_rr;      // register / memory two-operand form
    logic is_acc;     // short accumulator-immediate form
    logic is_grp;     // group immediate form
    logic size_bit;   // opcode bit 0
    logic dir_bit;    // opcode bit 1 (register form only)
    logic short_imm;  // 8-bit immediate on a wide operand
  } opclass_t;

  // Operand width from size bit and override prefix.
  function automatic opw_e width_pick(input logic size_bit, input logic pfx);
    if (!size_bit)  return OPW_8;
    else if (pfx)   return OPW_16;
    else            return OPW_32;
  endfunction

  // Sign-extend the low bytes of the raw immediate according to its size.
  function automatic logic [IMM_BITS-1:0] imm_sext(input logic [IMM_BITS-1:0] raw,
                                                   input opw_e isz);
    logic [IMM_BITS-1:0] r;
    case (isz)
      OPW_8:   r = {{(IMM_BITS-8){raw[7]}}, raw[7:0]};
      OPW_16:  r = {{(IMM_BITS-16){raw[15]}}, raw[15:0]};
      default: r = raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/addop_form_classify.sv
module addop_form_classify
  import addop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OPB_BITS-1:0] op,
  output opclass_t            cls,
  output logic                unsup
);

  always_comb begin
    cls = '0;
    case (op)
      8'h00, 8'h01, 8'h02, 8'h03: begin
        cls.is_rr    = 1'b1;
        cls.size_bit = op[0];
        cls.dir_bit  = op[1];
      end
      8'h04, 8'h05: begin
        cls.is_acc   = 1'b1;
        cls.size_bit = op[0];
      end
      8'h80: begin
        cls.is_grp   = 1'b1;
      end
      8'h81: begin
        cls.is_grp   = 1'b1;
        cls.size_bit = 1'b1;
      end
      8'h83: begin
        cls.is_grp    = 1'b1;
        cls.size_bit  = 1'b1;
        cls.short_imm = 1'b1;
      end
      default: cls = '0;
    endcase
  end

  assign unsup = !(cls.is_rr || cls.is_acc || cls.is_grp);

  // R10: a byte never matches two forms
  a_r10_one_form: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cls.is_rr, cls.is_acc, cls.is_grp}));

endmodule

// File: rtl/addop_operand_route.sv
module addop_operand_route
  import addop_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  opclass_t             cls,
  input  logic [OPB_BITS-1:0]  modrm,
  output logic                 dst_mem,
  output logic [RNUM_BITS-1:0] dst_num,
  output srck_e                src_kind,
  output logic [RNUM_BITS-1:0] src_num,
  output logic                 ext_bad
);

  logic [1:0]           mode_f;
  logic [RNUM_BITS-1:0] reg_f;
  logic [RNUM_BITS-1:0] rm_f;
  logic                 rm_is_mem;

  assign mode_f    = modrm[7:6];
  assign reg_f     = modrm[5:3];
  assign rm_f      = modrm[2:0];
  assign rm_is_mem = (mode_f != 2'b11);

  always_comb begin
    dst_mem  = 1'b0;
    dst_num  = '0;
    src_kind = SRC_REG;
    src_num  = '0;
    ext_bad  = 1'b0;
    if (cls.is_rr) begin
      if (cls.dir_bit) begin
        dst_num  = reg_f;
        src_num  = rm_f;
        src_kind = rm_is_mem ? SRC_MEM : SRC_REG;
      end else begin
        dst_mem  = rm_is_mem;
        dst_num  = rm_f;
        src_num  = reg_f;
      end
    end else if (cls.is_acc) begin
      src_kind = SRC_IMM;
    end else if (cls.is_grp) begin
      dst_mem  = rm_is_mem;
      dst_num  = rm_f;
      src_kind = SRC_IMM;
      ext_bad  = (reg_f != '0);
    end
  end

  // R4: never two memory operands
  a_r4_single_mem: assert property (@(posedge clk) disable iff (!rst_n)
    !(dst_mem && (src_kind == SRC_MEM)));

  // R9: accumulator form always targets register 0
  a_r9_acc_target: assert property (@(posedge clk) disable iff (!rst_n)
    cls.is_acc |-> (!dst_mem && dst_num == '0));

endmodule

// File: rtl/addop_imm_extend.sv
module addop_imm_extend
  import addop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  opclass_t            cls,
  input  logic                pfx,
  input  logic [IMM_BITS-1:0] raw,
  output opw_e                width,
  output logic                has_imm,
  output logic [IMM_BITS-1:0] imm_val
);

  opw_e imm_size;

  assign width   = (cls.is_rr || cls.is_acc || cls.is_grp) ? width_pick(cls.size_bit, pfx) : OPW_8;
  assign has_imm = cls.is_acc || cls.is_grp;

  always_comb begin
    if (cls.short_imm) imm_size = OPW_8;
    else               imm_size = width;
  end

  assign imm_val = has_imm ? imm_sext(raw, imm_size) : '0;

  // R5 / R7: an 8-bit-sized immediate carries its sign in the upper bits
  a_r7_short_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (has_imm && (cls.short_imm || width == OPW_8)) |->
      (imm_val[IMM_BITS-1:8] == {(IMM_BITS-8){raw[7]}}));

  // R11: size bit clear keeps the 8-bit width whatever the prefix
  a_r11_narrow_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!cls.size_bit) |-> (width == OPW_8));

endmodule

// File: rtl/addop_decode.sv
module addop_decode
  import addop_pkg::*;
#(
  parameter int unsigned IMM_W = addop_pkg::IMM_BITS,
  parameter int unsigned OPB_W = addop_pkg::OPB_BITS,
  parameter int unsigned RN_W  = addop_pkg::RNUM_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPB_W-1:0] op_byte,
  input  logic [OPB_W-1:0] modrm_byte,
  input  logic             pfx_opsize,
  input  logic [IMM_W-1:0] imm_bytes,
  output logic             out_valid,
  output logic [1:0]       width_code,
  output logic             dst_mem,
  output logic [RN_W-1:0]  dst_num,
  output logic [1:0]       src_kind,
  output logic [RN_W-1:0]  src_num,
  output logic             has_imm,
  output logic [IMM_W-1:0] imm_value,
  output logic             ext_bad,
  output logic             unsupported
);

  opclass_t             cls_w;
  logic                 unsup_w;
  logic                 dmem_w;
  logic [RN_W-1:0]      dnum_w;
  srck_e                skind_w;
  logic [RN_W-1:0]      snum_w;
  logic                 bad_w;
  opw_e                 width_w;
  logic                 himm_w;
  logic [IMM_W-1:0]     imm_w;

  addop_form_classify u_cls (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op_byte),
    .cls   (cls_w),
    .unsup (unsup_w)
  );

  addop_operand_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .cls      (cls_w),
    .modrm    (modrm_byte),
    .dst_mem  (dmem_w),
    .dst_num  (dnum_w),
    .src_kind (skind_w),
    .src_num  (snum_w),
    .ext_bad  (bad_w)
  );

  addop_imm_extend u_imm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cls     (cls_w),
    .pfx     (pfx_opsize),
    .raw     (imm_bytes),
    .width   (width_w),
    .has_imm (himm_w),
    .imm_val (imm_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      width_code  <= '0;
      dst_mem     <= 1'b0;
      dst_num     <= '0;
      src_kind    <= '0;
      src_num     <= '0;
      has_imm     <= 1'b0;
      imm_value   <= '0;
      ext_bad     <= 1'b0;
      unsupported <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        width_code  <= width_w;
        dst_mem     <= dmem_w;
        dst_num     <= dnum_w;
        src_kind    <= skind_w;
        src_num     <= snum_w;
        has_imm     <= himm_w;
        imm_value   <= imm_w;
        ext_bad     <= bad_w;
        unsupported <= unsup_w;
      end
    end
  end

  // R1: result strobe follows the request by one edge
  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10: unsupported decode shows nothing else
  a_r10_unsup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && unsupported) |-> (!has_imm && !ext_bad && !dst_mem && dst_num == '0));

  // R8: bad extension only on an immediate decode
  a_r8_bad_has_imm: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ext_bad) |-> (has_imm && src_kind == 2'd2));

  // R1: fields hold between strobes
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !out_valid) |=> $stable(imm_value));

endmodule

// File: tb/sim_addop_decode.sv
`timescale 1ns/1ps
module sim_addop_decode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  op_byte = '0;
  logic [7:0]  modrm_byte = '0;
  logic        pfx_opsize = 1'b0;
  logic [31:0] imm_bytes = '0;
  logic        out_valid;
  logic [1:0]  width_code;
  logic        dst_mem;
  logic [2:0]  dst_num;
  logic [1:0]  src_kind;
  logic [2:0]  src_num;
  logic        has_imm;
  logic [31:0] imm_value;
  logic        ext_bad;
  logic        unsupported;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  addop_decode u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_byte(op_byte),
    .modrm_byte(modrm_byte), .pfx_opsize(pfx_opsize), .imm_bytes(imm_bytes),
    .out_valid(out_valid), .width_code(width_code), .dst_mem(dst_mem),
    .dst_num(dst_num), .src_kind(src_kind), .src_num(src_num),
    .has_imm(has_imm), .imm_value(imm_value), .ext_bad(ext_bad),
    .unsupported(unsupported)
  );

  // {width2, dmem1, dnum3, skind2, snum3, himm1, imm32, bad1, unsup1} = 46 bits
  logic [45:0] q_exp[$];
  string       q_tag[$];

  function automatic logic [45:0] model(input logic [7:0] op, input logic [7:0] m,
                                        input logic p, input logic [31:0] im);
    logic [1:0] w; logic dm; logic [2:0] dn; logic [1:0] sk; logic [2:0] sn;
    logic hi; logic [31:0] iv; logic bd; logic un;
    logic reg_mode;
    w = 0; dm = 0; dn = 0; sk = 0; sn = 0; hi = 0; iv = 0; bd = 0; un = 0;
    reg_mode = (m[7] & m[6]);
    if (op <= 8'h03) begin
      w = op[0] ? (p ? 2'd1 : 2'd2) : 2'd0;
      if (op[1] == 1'b0) begin
        dn = m[2:0]; dm = ~reg_mode; sn = m[5:3]; sk = 0;
      end else begin
        dn = m[5:3]; dm = 0; sn = m[2:0]; sk = reg_mode ? 2'd0 : 2'd1;
      end
    end else if (op == 8'h04) begin
      hi = 1; sk = 2; iv = im[7] ? (32'hFFFFFF00 | im[7:0]) : {24'h0, im[7:0]};
    end else if (op == 8'h05 || op == 8'h81) begin
      w = p ? 2'd1 : 2'd2; hi = 1; sk = 2;
      if (p) iv = im[15] ? (32'hFFFF0000 | im[15:0]) : {16'h0, im[15:0]};
      else   iv = im;
      if (op == 8'h81) begin dn = m[2:0]; dm = ~reg_mode; bd = (m[5:3] != 0); end
    end else if (op == 8'h80 || op == 8'h83) begin
      w = (op == 8'h83) ? (p ? 2'd1 : 2'd2) : 2'd0;
      hi = 1; sk = 2; dn = m[2:0]; dm = ~reg_mode; bd = (m[5:3] != 0);
      iv = im[7] ? (32'hFFFFFF00 | im[7:0]) : {24'h0, im[7:0]};
    end else begin
      un = 1;
    end
    return {w, dm, dn, sk, sn, hi, iv, bd, un};
  endfunction

  task automatic send(input logic [7:0] op, input logic [7:0] m, input logic p,
                      input logic [31:0] im, input string tag);
    @(negedge clk);
    op_byte = op; modrm_byte = m; pfx_opsize = p; imm_bytes = im; in_valid = 1'b1;
    q_exp.push_back(model(op, m, p, im));
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [45:0] got;
      got = {width_code, dst_mem, dst_num, src_kind, src_num, has_imm, imm_value,
             ext_bad, unsupported};
      n_chk++;
      if (q_exp.size() == 0) begin
        n_bad++;
        $display("FAIL R1 unexpected out_valid got %h exp none", got);
      end else begin
        logic [45:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (got !== e) begin
          n_bad++;
          $display("FAIL %s got %h exp %h", t, got, e);
        end
      end
    end
  end

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired got running exp finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    n_chk++;
    if ({out_valid, width_code, dst_mem, dst_num, src_kind, src_num, has_imm,
         imm_value, ext_bad, unsupported} !== '0) begin
      n_bad++;
      $display("FAIL R1 reset state got nonzero exp zero");
    end
    rst_n = 1'b1;
    idle(2);

    // R3 direction, register-register
    send(8'h00, 8'hC1, 1'b0, 32'h0, "R3 00 C1");
    send(8'h02, 8'hC8, 1'b0, 32'h0, "R3 02 C8");
    // R2 widths
    send(8'h01, 8'hD8, 1'b0, 32'h0, "R2 01 w32");
    send(8'h01, 8'hD8, 1'b1, 32'h0, "R2 01 w16");
    // R4 memory operands
    send(8'h01, 8'h3B, 1'b0, 32'h0, "R4 01 mem dst");
    send(8'h03, 8'h46, 1'b1, 32'h0, "R4 03 mem src");
    send(8'h03, 8'h84, 1'b0, 32'h0, "R4 03 mode10");
    // R11 prefix ignored on 8-bit forms
    send(8'h00, 8'h1A, 1'b1, 32'h0, "R11 00 pfx");
    send(8'h02, 8'hE3, 1'b1, 32'h0, "R11 02 pfx");
    idle(1);
    // R9 accumulator forms, addressing byte ignored
    send(8'h04, 8'h00, 1'b0, 32'h0000_0080, "R9 04 a");
    send(8'h04, 8'hFF, 1'b0, 32'h0000_0080, "R9 04 modrm ignored");
    send(8'h04, 8'h5D, 1'b1, 32'h1234_567F, "R11 04 pfx");
    send(8'h05, 8'h3F, 1'b0, 32'h1234_5678, "R9 05 w32");
    send(8'h05, 8'hC7, 1'b1, 32'h0000_8001, "R9 05 w16");
    // R5 8-bit group immediate
    send(8'h80, 8'hC3, 1'b0, 32'hFFFF_FF7F, "R5 80 pos");
    send(8'h80, 8'h06, 1'b1, 32'h0000_00C4, "R11 80 pfx");
    // R6 full immediate
    send(8'h81, 8'h05, 1'b0, 32'hDEAD_BEEF, "R6 81 w32");
    send(8'h81, 8'hC2, 1'b1, 32'hAAAA_7FFF, "R6 81 w16");
    send(8'h81, 8'hC2, 1'b1, 32'h0000_9000, "R6 81 w16 neg");
    // R7 sign-extended short immediate
    send(8'h83, 8'hC0, 1'b0, 32'h0000_00F0, "R7 83 w32");
    send(8'h83, 8'h44, 1'b1, 32'h0000_0070, "R7 83 w16");
    // R8 bad extension
    send(8'h80, 8'hD9, 1'b0, 32'h0000_0001, "R8 80 ext3");
    send(8'h83, 8'hF8, 1'b0, 32'h0000_0001, "R8 83 ext7");
    send(8'h81, 8'h38, 1'b0, 32'h0000_0001, "R8 81 ext7");
    // R10 unsupported
    send(8'h82, 8'hC0, 1'b0, 32'hFFFF_FFFF, "R10 82");
    send(8'h0F, 8'hC0, 1'b1, 32'h1, "R10 0F");
    send(8'h10, 8'h38, 1'b0, 32'h0000_00FF, "R10 10");
    send(8'h06, 8'hC0, 1'b0, 32'h0000_0080, "R10 06");
    idle(3);

    // R1 no strobe without request
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle out_valid got %b exp 0", out_valid);
    end
    // R1 fields hold while idle (last decode: unsupported)
    n_chk++;
    if (unsupported !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 hold unsupported got %b exp 1", unsupported);
    end
    n_chk++;
    if (q_exp.size() != 0) begin
      n_bad++;
      $display("FAIL R1 pending results got %0d exp 0", q_exp.size());
    end
    finish_run();
  end

endmodule